// File: doc/BRIEF.md
# Multi-Mode Preset Counter (single axis)

This block is the counting core for one axis of a motion-feedback front end. Count pulses arrive already decoded, one enable pulse per step with a direction bit. They move a counter whose wrap or limit policy is chosen by a 2-bit mode input. A preset register supplies the load value and also serves as the bound for the modulo and range policies. A live comparator reports when the counter equals the preset.

Software never sees the live counter. A capture strobe, either a command or a hardware input, copies the counter into a holding latch, and the latch is what gets read. An 8-bit status word carries sticky overflow and underflow flags, the live equality, a lock flag for the non-recycling policy, and the direction of the last pulse. A clear command zeroes the counter, and a separate command clears the sticky flags.

Top module: `pc_axis_counter`

## Requirements
- R1: After reset the counter, preset and capture latch are all zero, `match` is 1 and `status` reads 0x04.
- R2: Mode 0 (free-running): an up pulse at all-ones gives 0 and sets overflow (status bit 0). A down pulse at 0 gives all-ones and sets underflow (status bit 1). Any other pulse adds or subtracts one.
- R3: Mode 1 (non-recycle): an up pulse at all-ones, or a down pulse at 0, leaves the counter unchanged, sets the matching flag and sets lock (status bit 3). While locked, pulses do not move the counter. A load or a clear releases the lock.
- R4: Mode 2 (modulo): an up pulse with counter equal to the preset gives 0 and sets overflow. A down pulse at 0 gives the preset value and sets underflow.
- R5: Mode 3 (range limit): an up pulse with counter equal to the preset holds the counter and sets overflow. A down pulse at 0 holds it and sets underflow. A pulse in the reverse direction moves the counter again.
- R6: `load_cmd` or `load_hw` copies the preset into the counter on the next edge. The copy uses the preset as it was before a write made in the same cycle.
- R7: `snap_cmd` or `snap_hw` copies the counter value held before that edge into `latch_q`. Without a capture strobe, `latch_q` keeps its value.
- R8: `match` and status bit 2 are 1 exactly when the counter equals the preset.
- R9: Overflow and underflow stay set until `stat_clr`. A set event in the same cycle as `stat_clr` wins.
- R10: Status bit 4 holds `cnt_up` from the most recent cycle with `cnt_en` high, locked or not. Status bits 7:5 read 0.
- R11: `clr_cmd` zeroes the counter and takes priority over a load and a pulse in the same cycle. A load in turn takes priority over a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Count policy: 0 free, 1 non-recycle, 2 modulo, 3 range |
| cnt_en | input | 1 | One count pulse in this cycle |
| cnt_up | input | 1 | Direction of the pulse, 1 = up |
| preset_wr | input | 1 | Write preset_data into the preset register |
| preset_data | input | WIDTH | New preset value |
| load_cmd | input | 1 | Command: counter takes the preset |
| load_hw | input | 1 | Hardware control: counter takes the preset |
| snap_cmd | input | 1 | Command: capture the counter into the latch |
| snap_hw | input | 1 | Hardware control: capture the counter into the latch |
| clr_cmd | input | 1 | Zero the counter and release lock |
| stat_clr | input | 1 | Clear the sticky overflow and underflow flags |
| latch_q | output | WIDTH | Captured counter value |
| status | output | 8 | {3'b0, dir, lock, equal, underflow, overflow} |
| match | output | 1 | Counter equals preset |

## Verification
The assertions take the strobe inputs to be synchronous, settled levels at each rising edge, and `mode` to stay constant between a pulse and its result. The stimulus drives every input a fixed delay after the edge and changes `mode` only while the counter is being cleared and reloaded. The range and modulo checks assume nothing about where the counter starts relative to the preset. For that reason the sweep loads every start value against every preset in both directions, with a run long enough to cross the bound and then reverse.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    PC_FREE  = 2'd0,
    PC_NOREC = 2'd1,
    PC_MOD   = 2'd2,
    PC_RANGE = 2'd3
  } pc_mode_e;

  localparam int ST_OVF  = 0;
  localparam int ST_UNF  = 1;
  localparam int ST_EQ   = 2;
  localparam int ST_LOCK = 3;
  localparam int ST_DIR  = 4;
  localparam int ST_W    = 8;
endpackage

// File: rtl/pc_step.sv
module pc_step #(
  parameter int WIDTH = 24
) (
  input  pc_pkg::pc_mode_e   mode,
  input  logic [WIDTH-1:0]   cur,
  input  logic [WIDTH-1:0]   bound,
  input  logic               up,
  output logic [WIDTH-1:0]   nxt,
  output logic               ovf_evt,
  output logic               unf_evt,
  output logic               lock_evt
);
  import pc_pkg::*;

  localparam logic [WIDTH-1:0] CMAX = '1;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  typedef struct packed {
    logic [WIDTH-1:0] v;
    logic             ovf;
    logic             unf;
    logic             lock;
  } step_t;

  function automatic step_t step_calc(pc_mode_e m, logic [WIDTH-1:0] c,
                                      logic [WIDTH-1:0] b, logic u);
    step_t r;
    logic  top_hit;
    logic  bot_hit;
    r.v    = u ? c + ONE : c - ONE;
    r.ovf  = 1'b0;
    r.unf  = 1'b0;
    r.lock = 1'b0;
    bot_hit = (c == '0);
    case (m)
      PC_FREE:  top_hit = (c == CMAX);
      PC_NOREC: top_hit = (c == CMAX);
      default:  top_hit = (c == b);
    endcase
    if (u && top_hit) begin
      r.ovf = 1'b1;
      case (m)
        PC_FREE:  r.v = '0;
        PC_MOD:   r.v = '0;
        default:  r.v = c;
      endcase
    end else if (!u && bot_hit) begin
      r.unf = 1'b1;
      case (m)
        PC_FREE:  r.v = CMAX;
        PC_MOD:   r.v = b;
        default:  r.v = c;
      endcase
    end
    r.lock = (m == PC_NOREC) && (r.ovf || r.unf);
    return r;
  endfunction

  step_t res;
  always_comb begin
    res      = step_calc(mode, cur, bound, up);
    nxt      = res.v;
    ovf_evt  = res.ovf;
    unf_evt  = res.unf;
    lock_evt = res.lock;
  end
endmodule

// File: rtl/pc_hold.sv
module pc_hold #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= d;
  end

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(q));
endmodule

// File: rtl/pc_status.sv
module pc_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pulse,
  input  logic       up,
  input  logic       ovf_set,
  input  logic       unf_set,
  input  logic       lock_set,
  input  logic       release_lock,
  input  logic       stat_clr,
  input  logic       eq,
  output logic       locked,
  output logic [7:0] status
);
  import pc_pkg::*;

  logic ovf_q, unf_q, dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      locked <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      ovf_q  <= ovf_set | (ovf_q & ~stat_clr);
      unf_q  <= unf_set | (unf_q & ~stat_clr);
      locked <= lock_set | (locked & ~release_lock);
      if (pulse) dir_q <= up;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_OVF]  = ovf_q;
    status[ST_UNF]  = unf_q;
    status[ST_EQ]   = eq;
    status[ST_LOCK] = locked;
    status[ST_DIR]  = dir_q;
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_OVF] && !stat_clr |=> status[ST_OVF]);
  // R9
  unf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr && !unf_set |=> !status[ST_UNF]);
  // R10
  dir_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> status[ST_DIR] == $past(up));
endmodule

// File: rtl/pc_axis_counter.sv
module pc_axis_counter #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             cnt_en,
  input  logic             cnt_up,
  input  logic             preset_wr,
  input  logic [WIDTH-1:0] preset_data,
  input  logic             load_cmd,
  input  logic             load_hw,
  input  logic             snap_cmd,
  input  logic             snap_hw,
  input  logic             clr_cmd,
  input  logic             stat_clr,
  output logic [WIDTH-1:0] latch_q,
  output logic [7:0]       status,
  output logic             match
);
  import pc_pkg::*;

  localparam logic [WIDTH-1:0] CMAX = '1;

  pc_mode_e         mode_e;
  logic [WIDTH-1:0] cnt_q, preset_q, step_nxt;
  logic             do_load, do_snap, step_go, locked;
  logic             ovf_evt, unf_evt, lock_evt;
  logic             ovf_set, unf_set, lock_set, release_lock;

  assign mode_e       = pc_mode_e'(mode);
  assign do_load      = load_cmd | load_hw;
  assign do_snap      = snap_cmd | snap_hw;
  assign release_lock = clr_cmd | do_load;
  assign step_go      = cnt_en & ~locked & ~release_lock;
  assign ovf_set      = step_go & ovf_evt;
  assign unf_set      = step_go & unf_evt;
  assign lock_set     = step_go & lock_evt;
  assign match        = (cnt_q == preset_q);

  pc_hold #(.WIDTH(WIDTH)) u_preset (
    .clk(clk), .rst_n(rst_n), .cap(preset_wr), .d(preset_data), .q(preset_q));

  pc_hold #(.WIDTH(WIDTH)) u_snap (
    .clk(clk), .rst_n(rst_n), .cap(do_snap), .d(cnt_q), .q(latch_q));

  pc_step #(.WIDTH(WIDTH)) u_step (
    .mode(mode_e), .cur(cnt_q), .bound(preset_q), .up(cnt_up),
    .nxt(step_nxt), .ovf_evt(ovf_evt), .unf_evt(unf_evt), .lock_evt(lock_evt));

  pc_status u_stat (
    .clk(clk), .rst_n(rst_n), .pulse(cnt_en), .up(cnt_up),
    .ovf_set(ovf_set), .unf_set(unf_set), .lock_set(lock_set),
    .release_lock(release_lock), .stat_clr(stat_clr), .eq(match),
    .locked(locked), .status(status));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_cmd) cnt_q <= '0;
    else if (do_load) cnt_q <= preset_q;
    else if (step_go) cnt_q <= step_nxt;
  end

  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> cnt_q == '0);
  // R6
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_load && !clr_cmd |=> cnt_q == $past(preset_q));
  // R7
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_snap |=> latch_q == $past(cnt_q));
  // R3
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !release_lock |=> $stable(cnt_q));
  // R5
  range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_go && mode_e == PC_RANGE && cnt_up && cnt_q == preset_q
      |=> $stable(cnt_q) && status[ST_OVF]);
  // R2
  free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_go && mode_e == PC_FREE && cnt_up && cnt_q == CMAX
      |=> cnt_q == '0 && status[ST_OVF]);
endmodule

// File: tb/sim_pc_axis_counter.sv
module sim_pc_axis_counter;
  localparam int W  = 4;
  localparam int MX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = '0;
  logic         cnt_en = 0, cnt_up = 0, preset_wr = 0;
  logic [W-1:0] preset_data = '0;
  logic         load_cmd = 0, load_hw = 0, snap_cmd = 0, snap_hw = 0;
  logic         clr_cmd = 0, stat_clr = 0;
  logic [W-1:0] latch_q;
  logic [7:0]   status;
  logic         match;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, m_pre = 0, m_lat = 0;
  bit m_ovf = 0, m_unf = 0, m_lock = 0, m_dir = 0;

  always #2 clk = ~clk;

  pc_axis_counter #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .preset_wr(preset_wr), .preset_data(preset_data), .load_cmd(load_cmd),
    .load_hw(load_hw), .snap_cmd(snap_cmd), .snap_hw(snap_hw),
    .clr_cmd(clr_cmd), .stat_clr(stat_clr), .latch_q(latch_q),
    .status(status), .match(match));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_status();
    return (int'(m_dir) << 4) | (int'(m_lock) << 3) |
           (int'(m_cnt == m_pre) << 2) | (int'(m_unf) << 1) | int'(m_ovf);
  endfunction

  // one clock with the given strobes; model advanced arithmetically
  task automatic step(string req, bit clr, bit ld, bit ldhw, bit pw, int pd,
                      bit en, bit up, bit sc, bit sh, bit sclr);
    bit ov = 0, un = 0;
    clr_cmd = clr; load_cmd = ld; load_hw = ldhw; preset_wr = pw;
    preset_data = W'(pd); cnt_en = en; cnt_up = up; snap_cmd = sc;
    snap_hw = sh; stat_clr = sclr;
    if (sc || sh) m_lat = m_cnt;
    if (clr) begin m_cnt = 0; m_lock = 0; end
    else if (ld || ldhw) begin m_cnt = m_pre; m_lock = 0; end
    else if (en && !m_lock) begin
      case (mode)
        2'd0: if (up && m_cnt == MX) begin m_cnt = 0; ov = 1; end
              else if (!up && m_cnt == 0) begin m_cnt = MX; un = 1; end
              else m_cnt = (m_cnt + (up ? 1 : MX)) % (MX + 1);
        2'd1: if (up && m_cnt == MX) begin ov = 1; m_lock = 1; end
              else if (!up && m_cnt == 0) begin un = 1; m_lock = 1; end
              else m_cnt = (m_cnt + (up ? 1 : MX)) % (MX + 1);
        2'd2: if (up && m_cnt == m_pre) begin m_cnt = 0; ov = 1; end
              else if (!up && m_cnt == 0) begin m_cnt = m_pre; un = 1; end
              else m_cnt = (m_cnt + (up ? 1 : MX)) % (MX + 1);
        default: if (up && m_cnt == m_pre) ov = 1;
              else if (!up && m_cnt == 0) un = 1;
              else m_cnt = (m_cnt + (up ? 1 : MX)) % (MX + 1);
      endcase
    end
    if (en) m_dir = up;
    m_ovf = ov | (m_ovf & !sclr);
    m_unf = un | (m_unf & !sclr);
    if (pw) m_pre = pd;
    @(posedge clk); #1;
    check({req, " status"}, int'(status), exp_status());
    check("R8 match", int'(match), int'(m_cnt == m_pre));
    check("R7 latch", int'(latch_q), m_lat);
    clr_cmd = 0; load_cmd = 0; load_hw = 0; preset_wr = 0; cnt_en = 0;
    snap_cmd = 0; snap_hw = 0; stat_clr = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    string tags[4];
    tags[0] = "R2"; tags[1] = "R3"; tags[2] = "R4"; tags[3] = "R5";
    #9 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", int'(status), 32'h04);
    check("R1 latch", int'(latch_q), 0);
    check("R1 match", int'(match), 1);

    // R11 clear beats load and pulse; R6 load beats pulse
    mode = 2'd0;
    step("R6", 0, 0, 0, 1, 9, 0, 0, 0, 0, 0);
    step("R11", 1, 1, 0, 0, 0, 1, 1, 0, 1, 0);
    step("R6", 0, 0, 1, 0, 0, 1, 0, 1, 0, 0);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    check("R6 load over pulse", int'(latch_q), 9);

    // R9 same-cycle set wins, then clear
    step("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    check("R9 set wins", int'(status[1]), 1);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R9 cleared", int'(status[1]), 0);

    // R3 lock released by load; R10 direction tracks locked pulses
    mode = 2'd1;
    step("R3", 0, 0, 0, 1, MX, 0, 0, 0, 0, 0);
    step("R3", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 1, 0, 0, 1, 0);
    check("R3 locked value", int'(latch_q), MX);
    check("R10 dir down", int'(status[4]), 0);
    step("R3", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    check("R3 released", int'(latch_q), MX - 1);

    // sweep: every mode, preset, start value and direction
    for (int md = 0; md < 4; md++)
      for (int p = 0; p <= MX; p++)
        for (int s = 0; s <= MX; s++)
          for (int d = 0; d < 2; d++) begin
            mode = 2'(md);
            step("R11", 1, 0, 0, 1, s, 0, 0, 0, 0, 1);
            step("R6", 0, s[0], !s[0], 1, p, 0, 0, 0, 0, 0);
            for (int k = 0; k < 24; k++)
              step(tags[md], 0, 0, 0, 0, 0, 1, (k < 18) ? d[0] : !d[0],
                   k[0], !k[0], 0);
          end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule